// File: doc/BRIEF.md
# Asynchronous Trace Pin Serializer

This block carries a single stream of trace bytes from the traced device to an external host over one output-only pin. Bytes arrive on a valid/ready port. Each accepted byte is turned into a serial frame and shifted out at a rate set by a clock prescaler. A run-time protocol field selects one of two line codes. In the UART-style code the line idles high, and each frame has a start bit, eight data bits and a stop bit. In the Manchester code the line idles low, and each bit carries a mid-bit transition. No multi-source framing is added: the pin carries the bytes as offered.

A master enable gates the whole path. While the enable is low the pin is held at its inactive level and offered bytes are taken and dropped. A busy output tells software or a host when the last frame has fully left the pin. Prescaler and protocol values are sampled only while no frame is in flight. A running frame always completes with the settings it started with.

Top module: `trace_pin_serializer`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, `pin_out` is 0, `busy` is 0 and `in_ready` is 1.
- R2: `in_ready` is 1 only when no frame is in progress. A byte is taken on a clock edge where `in_valid` and `in_ready` are both 1. With the enable high and a valid protocol, that edge starts a frame and raises `busy`, which stays 1 until the frame's last slot ends. Exactly one byte is taken per frame.
- R3: Each line slot lasts exactly `cfg_prescale`+1 clocks. A UART-style bit is one slot and a Manchester bit is two slots. For example, a prescale of 39 gives 40 clocks per bit, which is 2 Mbit/s from an 80 MHz clock.
- R4: `cfg_proto` = 2 selects the UART-style code. While idle and enabled the pin is 1. A frame is 10 slots: a 0 start bit, data bit 0 through data bit 7, then a 1 stop bit. The first slot appears on the accepting clock edge.
- R5: `cfg_proto` = 1 selects Manchester coding. While idle the pin is 0. A frame is a start bit of value 1 followed by data bits 0 to 7, which makes 18 slots. A 1 is sent as high then low and a 0 as low then high. The pin returns to 0 when the frame ends.
- R6: `cfg_proto` = 0 or 3 disables the serializer. The pin stays 0, `busy` stays 0, and offered bytes are taken and discarded.
- R7: While `trace_en` is 0 the pin is 0, `busy` is 0, `in_ready` is 1 and offered bytes are discarded. Dropping `trace_en` during a frame abandons that frame at the next clock edge.
- R8: Changes to `cfg_prescale` or `cfg_proto` made during a frame do not alter that frame. The next accepted frame uses the values present on its accepting edge. While idle, the pin sits at the idle level of the protocol currently programmed.
- R9: If a byte is waiting when a frame ends, the pin holds its idle level for exactly one clock. The next frame then starts on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Trace clock; all bit timing derives from it |
| rst_n | input | 1 | Active-low synchronous reset |
| trace_en | input | 1 | Master enable; low forces the pin inactive and drops input |
| cfg_prescale | input | PRESC_W | Slot length minus one, in clocks |
| cfg_proto | input | 2 | Line code: 1 Manchester, 2 UART-style, others disabled |
| in_valid | input | 1 | A trace byte is offered |
| in_data | input | 8 | Offered trace byte |
| in_ready | output | 1 | Block can take a byte this cycle |
| pin_out | output | 1 | Registered serial trace pin |
| busy | output | 1 | A frame is being shifted out |

## Verification
Two events can land on one clock edge. A configuration write can coincide with a byte being accepted. The end of a frame can coincide with the next byte waiting to be taken. The first case is provoked by changing the prescale and protocol in the very cycle a byte is offered, and again one cycle after it is taken. The second is provoked by holding a second byte on the port through a whole frame. Each resulting waveform is compared clock by clock against a line model built from the requirements. The model checks that the first frame keeps its latched settings, that the next frame adopts the new ones, and that the gap between back-to-back frames is exactly one idle clock. A third overlap, the enable dropping in the middle of a slot, is judged at the ports in the cycle that follows.

// File: rtl/tps_pkg.sv
package tps_pkg;

    localparam int DATA_W    = 8;
    localparam int FRAME_W   = DATA_W + 2;
    localparam int NRZ_SLOTS = DATA_W + 2;
    localparam int MAN_SLOTS = 2 * (DATA_W + 1);
    localparam int SLOT_W    = $clog2(MAN_SLOTS);

    localparam logic [SLOT_W-1:0] NRZ_LAST = SLOT_W'(NRZ_SLOTS - 1);
    localparam logic [SLOT_W-1:0] MAN_LAST = SLOT_W'(MAN_SLOTS - 1);

    typedef enum logic [1:0] {
        LINE_OFF_LO = 2'd0,
        LINE_MANCH  = 2'd1,
        LINE_UART   = 2'd2,
        LINE_OFF_HI = 2'd3
    } line_code_e;

    function automatic logic code_is_live(input logic [1:0] code);
        return (code == LINE_MANCH) || (code == LINE_UART);
    endfunction

    // Level driven for one slot: Manchester inverts the bit in its second half.
    function automatic logic slot_level(input logic bit_v, input logic second_half,
                                        input logic manch);
        return manch ? (bit_v ^ second_half) : bit_v;
    endfunction

endpackage

// File: rtl/tps_slot_timer.sv
module tps_slot_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         slot_end
);

    logic [W-1:0] cnt_d, cnt_q;

    assign slot_end = run && (cnt_q == limit);

    always_comb begin
        cnt_d = cnt_q;
        if (!run || slot_end) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/tps_frame_builder.sv
module tps_frame_builder
    import tps_pkg::*;
(
    input  logic [DATA_W-1:0]  data,
    input  logic               manch,
    output logic [FRAME_W-1:0] frame,
    output logic [SLOT_W-1:0]  last_slot
);

    logic [FRAME_W-1:0] uart_v;
    logic [FRAME_W-1:0] manch_v;

    assign uart_v[0]          = 1'b0;
    assign uart_v[FRAME_W-1]  = 1'b1;
    assign manch_v[0]         = 1'b1;
    assign manch_v[FRAME_W-1] = 1'b0;

    generate
        for (genvar i = 0; i < DATA_W; i++) begin : g_payload
            assign uart_v[i+1]  = data[i];
            assign manch_v[i+1] = data[i];
        end
    endgenerate

    assign frame     = manch ? manch_v : uart_v;
    assign last_slot = manch ? MAN_LAST : NRZ_LAST;

endmodule

// File: rtl/trace_pin_serializer.sv
module trace_pin_serializer
    import tps_pkg::*;
#(
    parameter int PRESC_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      trace_en,
    input  logic [PRESC_W-1:0]        cfg_prescale,
    input  logic [1:0]                cfg_proto,
    input  logic                      in_valid,
    input  logic [tps_pkg::DATA_W-1:0] in_data,
    output logic                      in_ready,
    output logic                      pin_out,
    output logic                      busy
);

    typedef struct packed {
        logic                active;
        logic [FRAME_W-1:0]  shreg;
        logic [SLOT_W-1:0]   slots_left;
        logic                half;
        logic                manch;
        logic [PRESC_W-1:0]  presc;
        logic                pin;
    } ser_state_t;

    ser_state_t s_d, s_q;

    logic               slot_end;
    logic [FRAME_W-1:0] fb_frame;
    logic [SLOT_W-1:0]  fb_last;
    logic               want_manch;

    assign want_manch = (cfg_proto == LINE_MANCH);

    tps_slot_timer #(.W(PRESC_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (s_q.active),
        .limit    (s_q.presc),
        .slot_end (slot_end)
    );

    tps_frame_builder u_builder (
        .data      (in_data),
        .manch     (want_manch),
        .frame     (fb_frame),
        .last_slot (fb_last)
    );

    always_comb begin
        s_d = s_q;

        // Settings track the inputs only between frames.
        if (!s_q.active) begin
            s_d.presc = cfg_prescale;
            s_d.manch = want_manch;
        end

        if (!trace_en) begin
            s_d.active = 1'b0;
            s_d.half   = 1'b0;
        end else if (!s_q.active) begin
            if (in_valid && code_is_live(cfg_proto)) begin
                s_d.active     = 1'b1;
                s_d.shreg      = fb_frame;
                s_d.slots_left = fb_last;
                s_d.half       = 1'b0;
            end
        end else if (slot_end) begin
            if (s_q.slots_left == '0) begin
                s_d.active = 1'b0;
                s_d.half   = 1'b0;
            end else begin
                s_d.slots_left = s_q.slots_left - SLOT_W'(1);
                if (s_q.manch && !s_q.half) begin
                    s_d.half = 1'b1;
                end else begin
                    s_d.half  = 1'b0;
                    s_d.shreg = s_q.shreg >> 1;
                end
            end
        end

        if (s_d.active) begin
            s_d.pin = slot_level(s_d.shreg[0], s_d.half, s_d.manch);
        end else begin
            s_d.pin = trace_en && (cfg_proto == LINE_UART);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign in_ready = !s_q.active;
    assign busy     = s_q.active;
    assign pin_out  = s_q.pin;

endmodule

// File: rtl/tps_checker.sv
module tps_checker #(
    parameter int PW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          trace_en,
    input logic [PW-1:0] cfg_prescale,
    input logic [1:0]    cfg_proto,
    input logic          in_valid,
    input logic          in_ready,
    input logic          pin_out,
    input logic          busy
);

    logic          take_live;
    logic [PW-1:0] presc_l;
    logic [31:0]   run_len;
    logic          prev_pin;
    logic          prev_busy;

    assign take_live = in_valid && in_ready && trace_en &&
                       (cfg_proto == 2'd1 || cfg_proto == 2'd2);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            presc_l   <= '0;
            run_len   <= 32'd0;
            prev_pin  <= 1'b0;
            prev_busy <= 1'b0;
        end else begin
            if (take_live) presc_l <= cfg_prescale;
            prev_pin  <= pin_out;
            prev_busy <= busy;
            if (busy && prev_busy && pin_out == prev_pin) run_len <= run_len + 32'd1;
            else run_len <= 32'd1;
        end
    end

    // R7: enable low forces the pin inactive with no frame running
    a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !trace_en |=> (!pin_out && !busy));

    // R6: a disabled line code never starts a frame
    a_r6_bad_code_no_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (cfg_proto == 2'd0 || cfg_proto == 2'd3)) |=> (!busy && !pin_out));

    // R2: an accepted byte starts a frame
    a_r2_take_starts_frame: assert property (@(posedge clk) disable iff (!rst_n)
        take_live |=> busy);

    // R4: UART-style start bit is low
    a_r4_uart_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        (take_live && cfg_proto == 2'd2) |=> !pin_out);

    // R4: UART-style idle line is high
    a_r4_uart_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && trace_en && cfg_proto == 2'd2 && !in_valid) |=> pin_out);

    // R5: Manchester frame opens high (start bit 1, first half)
    a_r5_manch_start_high: assert property (@(posedge clk) disable iff (!rst_n)
        (take_live && cfg_proto == 2'd1) |=> pin_out);

    // R3: no level inside a frame is shorter than one slot
    a_r3_slot_min_width: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && prev_busy && pin_out != prev_pin) |-> (run_len >= 32'(presc_l) + 32'd1));

endmodule

bind trace_pin_serializer tps_checker #(.PW(PRESC_W)) u_tps_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .trace_en     (trace_en),
    .cfg_prescale (cfg_prescale),
    .cfg_proto    (cfg_proto),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .pin_out      (pin_out),
    .busy         (busy)
);

// File: tb/trace_pin_serializer_test.sv
module trace_pin_serializer_test;

    localparam int PW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          trace_en = 1'b0;
    logic [PW-1:0] cfg_prescale = '0;
    logic [1:0]    cfg_proto = 2'd0;
    logic          in_valid = 1'b0;
    logic [7:0]    in_data = 8'h00;
    logic          in_ready;
    logic          pin_out;
    logic          busy;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    trace_pin_serializer #(.PRESC_W(PW)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .trace_en     (trace_en),
        .cfg_prescale (cfg_prescale),
        .cfg_proto    (cfg_proto),
        .in_valid     (in_valid),
        .in_data      (in_data),
        .in_ready     (in_ready),
        .pin_out      (pin_out),
        .busy         (busy)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Line model from R3/R4/R5: level in cycle i after the accepting edge.
    function automatic logic exp_level(input logic [7:0] d, input bit man,
                                       input int p, input int i);
        int   slot;
        int   bn;
        logic b;
        slot = i / (p + 1);
        if (!man) begin
            if (slot == 0) return 1'b0;
            if (slot == 9) return 1'b1;
            return d[slot-1];
        end
        bn = slot / 2;
        b  = (bn == 0) ? 1'b1 : d[bn-1];
        return (slot % 2 == 1) ? ~b : b;
    endfunction

    // Called at the falling edge right after the accepting edge; returns at
    // the falling edge right after the frame's final edge.
    task automatic check_frame(input logic [7:0] d, input bit man, input int p,
                               input string req);
        int   n;
        int   bad;
        int   first;
        logic got;
        logic want;
        n = (man ? 18 : 10) * (p + 1);
        bad = 0;
        first = -1;
        got = 1'b0;
        want = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (pin_out !== exp_level(d, man, p, i) || busy !== 1'b1 || in_ready !== 1'b0) begin
                if (first < 0) begin
                    first = i;
                    got   = pin_out;
                    want  = exp_level(d, man, p, i);
                end
                bad++;
            end
            @(negedge clk);
        end
        chk(bad == 0, req, $sformatf("frame %02h waveform, first bad cycle %0d", d, first),
            longint'(got), longint'(want));
        chk(busy === 1'b0, req, "busy after frame end", longint'(busy), 0);
    endtask

    task automatic set_cfg(input bit en, input logic [1:0] code, input int p);
        trace_en     = en;
        cfg_proto    = code;
        cfg_prescale = PW'(p);
    endtask

    task automatic send(input logic [7:0] d);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk(pin_out === 1'b0, "R1", "pin in reset", longint'(pin_out), 0);
        chk(busy === 1'b0, "R1", "busy in reset", longint'(busy), 0);
        chk(in_ready === 1'b1, "R1", "ready in reset", longint'(in_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pin_out === 1'b0 && busy === 1'b0 && in_ready === 1'b1, "R1",
            "outputs after release", {pin_out, busy, in_ready}, 3'b001);
    endtask

    task automatic t_uart;
        set_cfg(1, 2'd2, 3);
        repeat (2) @(negedge clk);
        chk(pin_out === 1'b1, "R4", "UART idle level", longint'(pin_out), 1);
        send(8'hA5); check_frame(8'hA5, 0, 3, "R4");
        chk(pin_out === 1'b1, "R4", "UART idle after frame", longint'(pin_out), 1);
        send(8'h01); check_frame(8'h01, 0, 3, "R4");
        set_cfg(1, 2'd2, 0);
        send(8'hFF); check_frame(8'hFF, 0, 0, "R3");
    endtask

    task automatic t_rate;
        set_cfg(1, 2'd2, 39);
        send(8'h55); check_frame(8'h55, 0, 39, "R3");
    endtask

    task automatic t_manch;
        set_cfg(1, 2'd1, 2);
        repeat (2) @(negedge clk);
        chk(pin_out === 1'b0, "R5", "Manchester idle level", longint'(pin_out), 0);
        send(8'h3C); check_frame(8'h3C, 1, 2, "R5");
        chk(pin_out === 1'b0, "R5", "Manchester idle after frame", longint'(pin_out), 0);
        set_cfg(1, 2'd1, 0);
        send(8'h00); check_frame(8'h00, 1, 0, "R5");
    endtask

    task automatic t_back_to_back;
        set_cfg(1, 2'd2, 1);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = 8'h96;
        @(negedge clk);
        in_data  = 8'h4B;   // held through the whole first frame
        check_frame(8'h96, 0, 1, "R2");
        chk(pin_out === 1'b1 && in_ready === 1'b1, "R9", "single idle gap",
            {pin_out, in_ready}, 2'b11);
        @(negedge clk);
        in_valid = 1'b0;
        check_frame(8'h4B, 0, 1, "R9");
        repeat (4) @(negedge clk);
        chk(busy === 1'b0, "R2", "no extra frame", longint'(busy), 0);
    endtask

    task automatic t_cfg_overlap;
        // new settings arrive in the same cycle the byte is offered
        set_cfg(1, 2'd2, 4);
        @(negedge clk);
        set_cfg(1, 2'd1, 1);
        in_valid = 1'b1;
        in_data  = 8'hC3;
        @(negedge clk);
        in_valid = 1'b0;
        set_cfg(1, 2'd2, 5);   // changed during the frame
        check_frame(8'hC3, 1, 1, "R8");
        chk(pin_out === 1'b1, "R8", "idle level follows new code", longint'(pin_out), 1);
        send(8'h81); check_frame(8'h81, 0, 5, "R8");
    endtask

    task automatic t_bad_code;
        int bad;
        for (int k = 0; k < 2; k++) begin
            set_cfg(1, (k == 0) ? 2'd0 : 2'd3, 1);
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = 8'hE7;
            chk(in_ready === 1'b1, "R6", "bad code still takes bytes", longint'(in_ready), 1);
            @(negedge clk);
            in_valid = 1'b0;
            bad = 0;
            for (int i = 0; i < 30; i++) begin
                if (pin_out !== 1'b0 || busy !== 1'b0) bad++;
                @(negedge clk);
            end
            chk(bad == 0, "R6", $sformatf("code %0d quiet cycles", cfg_proto), bad, 0);
        end
    endtask

    task automatic t_disable;
        int bad;
        set_cfg(1, 2'd2, 3);
        send(8'h5A);
        repeat (10) @(negedge clk);
        trace_en = 1'b0;
        @(negedge clk);
        chk(pin_out === 1'b0 && busy === 1'b0 && in_ready === 1'b1, "R7",
            "abort mid-frame", {pin_out, busy, in_ready}, 3'b001);
        in_valid = 1'b1;
        in_data  = 8'h33;
        @(negedge clk);
        in_valid = 1'b0;
        bad = 0;
        for (int i = 0; i < 20; i++) begin
            if (pin_out !== 1'b0 || busy !== 1'b0) bad++;
            @(negedge clk);
        end
        chk(bad == 0, "R7", "byte dropped while disabled", bad, 0);
        trace_en = 1'b1;
        @(negedge clk);
        chk(pin_out === 1'b1 && busy === 1'b0, "R7", "re-enable returns to idle",
            {pin_out, busy}, 2'b10);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_uart();
        t_rate();
        t_manch();
        t_back_to_back();
        t_cfg_overlap();
        t_bad_code();
        t_disable();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule